// File: doc/BRIEF.md
# Status Register Protection Controller

This block keeps the eight-bit status byte of a small serial non-volatile memory and decides, request by request, whether a write to the array or to the status byte may go ahead. It is placed after the serial command decoder. The decoder hands it single-cycle events for write-enable, write-disable, a status write (data byte plus the clock count seen before chip select rose), and an array write with its target address. The block answers each request that is allowed with a one-cycle permit pulse. It also drives the status byte that a status read shifts out.

Two levels of protection are built in. A two-bit block-protect field fences off the top quarter, the top half or everything above the 32-byte counter page. That page is never fenced, because its writes are policed by a separate monotonic comparator. A sticky status-write-disable bit, combined with a low level on the protect pin, locks the status byte itself. The protection fields are treated as non-volatile. They change only through an accepted status write or the factory-load input, and a soft reset leaves them alone. The write-enable latch is cleared by a soft reset. While the memory is busy programming, the protection fields seen by a status read stay at their pre-write values, while the enable and busy bits follow live state.

Top module: `wprot_status_ctrl`

## Requirements
- R1: With `nv_init_n` low at a clock edge, the status byte becomes 0x10 (bit 4 set, all others clear) when `erased_i` and `busy_i` are low, and the write-enable latch (bit 1) is clear.
- R2: `wren_i` sets bit 1 at the next edge and `wrdi_i` clears it; when both arrive together the clear wins; a low `rst_n` clears bit 1 but leaves bits 7, 3 and 2 unchanged.
- R3: A status write is accepted only with bit 1 set, `busy_i` low and `wrsr_clks_i` equal to 16; it stores data bit 7 into bit 7 and data bits 3:2 into bits 3:2, and data bits 6, 5, 4, 1 and 0 have no effect; a status write with any other clock count changes nothing, not even bit 1.
- R4: With stored bit 7 set and `wp_n_i` low, a status write is refused; with `wp_n_i` high it is accepted again and bits 3:2 keep their values until rewritten; with bit 7 clear the pin level has no effect.
- R5: Block-protect code 00 fences nothing, 01 fences 0x300..0x3FF, 10 fences 0x200..0x3FF and 11 fences 0x020..0x3FF; addresses 0x000..0x01F are never fenced.
- R6: An array write gets `wr_permit_o` high for exactly the cycle after the request only when bit 1 is set, `busy_i` is low and the address is not fenced.
- R7: Every array write request and every status write with a count of 16 that arrives while `busy_i` is low clears bit 1 at the next edge, whether it is permitted or not.
- R8: While `busy_i` is high, write requests, `wren_i` and `wrdi_i` have no effect and no permit is given; bit 0 follows `busy_i` in the same cycle.
- R9: Bits 7, 3 and 2 of the status byte keep their previous values from the permit pulse until `busy_i` has returned low, and show newly stored values one edge after that.
- R10: Bit 6 follows `erased_i`, bit 5 reads 0, and bit 4 takes the value of `cmp_lower_i` at any edge where `cmp_upd_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low soft reset (volatile state only) |
| nv_init_n | input | 1 | Synchronous active-low load of the delivery values into the non-volatile fields |
| wp_n_i | input | 1 | Write-protect pin level, low means protect |
| wren_i | input | 1 | Write-enable event |
| wrdi_i | input | 1 | Write-disable event |
| wrsr_req_i | input | 1 | Status write request, one cycle at chip-select rise |
| wrsr_clks_i | input | 6 | Serial clocks counted before chip select rose |
| wrsr_data_i | input | 8 | Status write data byte |
| arr_req_i | input | 1 | Array write request, one cycle |
| arr_addr_i | input | 10 | Array write target address |
| busy_i | input | 1 | Internal programming cycle in progress |
| cmp_upd_i | input | 1 | Comparator result strobe |
| cmp_lower_i | input | 1 | Comparator result: new value was lower |
| erased_i | input | 1 | Array erased indication |
| wr_permit_o | output | 1 | One-cycle pulse granting the last request |
| status_o | output | 8 | Status byte for reads |

## Verification
Array write requests are swept over addresses at the edges of each fenced region (0x01F/0x020, 0x1FF/0x200, 0x2FF/0x300, 0x3FF) under all four block-protect codes. This shows whether the decode boundaries are correct and whether the counter page stays exempt. Status writes are tried with the latch clear, with the wrong clock count, and with the pin low under both values of the lock bit. This tells apart the enable rule, the count rule and the pin-locked rule. A write followed by a long busy window, with enable and write events injected inside it, shows whether the frozen fields hold and whether events during programming are dropped.

// File: rtl/wps_pkg.sv
// Package: shared types and bit positions for the status protection controller.
// Assumes an eight-bit status byte; positions are fixed because the serial
// read path shifts the byte out as-is.
package wps_pkg;

    localparam int SR_LOCK  = 7;
    localparam int SR_UV    = 6;
    localparam int SR_SPARE = 5;
    localparam int SR_INC   = 4;
    localparam int SR_BPH   = 3;
    localparam int SR_BPL   = 2;
    localparam int SR_WEL   = 1;
    localparam int SR_WIP   = 0;

    // Non-volatile protection fields
    typedef struct packed {
        logic       lock;
        logic [1:0] fence;
    } nv_prot_t;

    localparam nv_prot_t NV_DELIVERY = '{lock: 1'b0, fence: 2'b00};
    localparam logic     INC_DELIVERY = 1'b1;

    // Pack live and stored fields into the status byte
    function automatic logic [7:0] pack_status(input nv_prot_t shown,
                                               input logic uv,
                                               input logic inc,
                                               input logic wel,
                                               input logic wip);
        logic [7:0] s;
        s           = '0;
        s[SR_LOCK]  = shown.lock;
        s[SR_UV]    = uv;
        s[SR_SPARE] = 1'b0;
        s[SR_INC]   = inc;
        s[SR_BPH]   = shown.fence[1];
        s[SR_BPL]   = shown.fence[0];
        s[SR_WEL]   = wel;
        s[SR_WIP]   = wip;
        return s;
    endfunction

endpackage

// File: rtl/wps_wel_latch.sv
// Module: write-enable latch.
// Sets on an enable event, clears on a disable event or on any consumed write
// attempt; clearing wins. Events are gated by the caller when busy.
// Assumes a synchronous active-low soft reset clears the latch.
module wps_wel_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic wel_o
);

    // Latch update with clear priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_o <= 1'b0;
        end else if (clr_i) begin
            wel_o <= 1'b0;
        end else if (set_i) begin
            wel_o <= 1'b1;
        end
    end

endmodule

// File: rtl/wps_fence_decode.sv
// Module: block-protect address decode.
// Reports whether an address falls in the region fenced by the two-bit code.
// Assumes ADDR_W >= 3 and PAGE_BYTES below the half-array base; the counter
// page [0, PAGE_BYTES) is always exempt.
module wps_fence_decode #(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        fence_i,
    output logic              hit_o
);

    localparam logic [ADDR_W-1:0] PAGE_END = ADDR_W'(PAGE_BYTES);

    logic in_page;
    logic in_quarter;
    logic in_half;

    // Region membership by the top address bits
    always_comb begin
        in_page    = (addr_i < PAGE_END);
        in_quarter = (addr_i[ADDR_W-1 -: 2] == 2'b11);
        in_half    = addr_i[ADDR_W-1];
    end

    // Code to region selection with page exemption
    always_comb begin
        unique case (fence_i)
            2'b00:   hit_o = 1'b0;
            2'b01:   hit_o = in_quarter;
            2'b10:   hit_o = in_half;
            default: hit_o = 1'b1;
        endcase
        if (in_page) begin
            hit_o = 1'b0;
        end
    end

endmodule

// File: rtl/wps_nv_fields.sv
// Module: non-volatile protection fields and their read-visible copy.
// The stored copy changes on an accepted status write or the delivery load;
// the shown copy follows it only while no write is pending or running.
// Assumes nothing here is touched by the soft reset.
module wps_nv_fields
    import wps_pkg::*;
(
    input  logic     clk,
    input  logic     nv_init_n,
    input  logic     wr_en_i,
    input  nv_prot_t wr_val_i,
    input  logic     hold_i,
    input  logic     cmp_upd_i,
    input  logic     cmp_lower_i,
    output nv_prot_t stored_o,
    output nv_prot_t shown_o,
    output logic     inc_o
);

    // Stored fields: delivery load first, then accepted writes
    always_ff @(posedge clk) begin
        if (!nv_init_n) begin
            stored_o <= NV_DELIVERY;
        end else if (wr_en_i) begin
            stored_o <= wr_val_i;
        end
    end

    // Shown fields: frozen while a write is pending or in progress
    always_ff @(posedge clk) begin
        if (!nv_init_n) begin
            shown_o <= NV_DELIVERY;
        end else if (!hold_i) begin
            shown_o <= stored_o;
        end
    end

    // Comparator flag
    always_ff @(posedge clk) begin
        if (!nv_init_n) begin
            inc_o <= INC_DELIVERY;
        end else if (cmp_upd_i) begin
            inc_o <= cmp_lower_i;
        end
    end

endmodule

// File: rtl/wprot_status_ctrl.sv
// Module: status register protection controller (top).
// Evaluates array and status write requests against the enable latch, busy
// state, block-protect fence and pin lock; pulses a permit one cycle later and
// assembles the status byte. Assumes request events are single-cycle and that
// array and status requests never coincide.
module wprot_status_ctrl
    import wps_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 32,
    parameter int WRSR_CLKS  = 16,
    parameter int CNT_W      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nv_init_n,
    input  logic              wp_n_i,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              wrsr_req_i,
    input  logic [CNT_W-1:0]  wrsr_clks_i,
    input  logic [7:0]        wrsr_data_i,
    input  logic              arr_req_i,
    input  logic [ADDR_W-1:0] arr_addr_i,
    input  logic              busy_i,
    input  logic              cmp_upd_i,
    input  logic              cmp_lower_i,
    input  logic              erased_i,
    output logic              wr_permit_o,
    output logic [7:0]        status_o
);

    localparam logic [CNT_W-1:0] CLK_MATCH = CNT_W'(WRSR_CLKS);

    logic     idle;
    logic     arr_try;
    logic     wrsr_try;
    logic     pin_lock;
    logic     fenced;
    logic     arr_go;
    logic     wrsr_go;
    logic     wel_q;
    logic     wel_set;
    logic     wel_clr;
    logic     srwd_st;
    logic     inc_q;
    nv_prot_t nv_stored;
    nv_prot_t nv_shown;
    nv_prot_t nv_new;

    // Request qualification
    always_comb begin
        idle     = rst_n && !busy_i;
        arr_try  = arr_req_i && idle;
        wrsr_try = wrsr_req_i && idle && (wrsr_clks_i == CLK_MATCH);
        srwd_st  = nv_stored.lock;
        pin_lock = srwd_st && !wp_n_i;
        arr_go   = arr_try && wel_q && !fenced;
        wrsr_go  = wrsr_try && wel_q && !pin_lock;
        wel_set  = wren_i && idle;
        wel_clr  = (wrdi_i && idle) || arr_try || wrsr_try;
        nv_new   = '{lock: wrsr_data_i[SR_LOCK],
                     fence: wrsr_data_i[SR_BPH:SR_BPL]};
    end

    wps_fence_decode #(
        .ADDR_W    (ADDR_W),
        .PAGE_BYTES(PAGE_BYTES)
    ) u_fence (
        .addr_i (arr_addr_i),
        .fence_i(nv_stored.fence),
        .hit_o  (fenced)
    );

    wps_wel_latch u_wel (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(wel_set),
        .clr_i(wel_clr),
        .wel_o(wel_q)
    );

    wps_nv_fields u_nv (
        .clk        (clk),
        .nv_init_n  (nv_init_n),
        .wr_en_i    (wrsr_go),
        .wr_val_i   (nv_new),
        .hold_i     (busy_i || wr_permit_o),
        .cmp_upd_i  (cmp_upd_i),
        .cmp_lower_i(cmp_lower_i),
        .stored_o   (nv_stored),
        .shown_o    (nv_shown),
        .inc_o      (inc_q)
    );

    // Permit pulse, one cycle after a granted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_permit_o <= 1'b0;
        end else begin
            wr_permit_o <= arr_go || wrsr_go;
        end
    end

    // Status byte assembly
    always_comb begin
        status_o = pack_status(nv_shown, erased_i, inc_q, wel_q, busy_i);
    end

endmodule

// File: rtl/wps_checker.sv
// Module: property checker for the status protection controller, bound to the
// top. Observes ports plus the stored lock bit and enable latch.
module wps_checker #(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              nv_init_n,
    input logic              wp_n_i,
    input logic              wrdi_i,
    input logic              wrsr_req_i,
    input logic              arr_req_i,
    input logic [ADDR_W-1:0] arr_addr_i,
    input logic              busy_i,
    input logic              wr_permit_o,
    input logic [7:0]        status_o,
    input logic              srwd_st,
    input logic              wel_q
);

    localparam logic [ADDR_W-1:0] PAGE_END = ADDR_W'(PAGE_BYTES);

    // R6: no enable, no permit
    a_r6_no_wel_no_permit: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req_i && !wel_q) |=> !wr_permit_o);

    // R8: busy blocks every grant
    a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && (arr_req_i || wrsr_req_i)) |=> !wr_permit_o);

    // R4: pin lock refuses status writes
    a_r4_pin_lock_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (wrsr_req_i && srwd_st && !wp_n_i) |=> !wr_permit_o);

    // R5: counter page is never fenced
    a_r5_page_exempt: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req_i && !busy_i && wel_q && (arr_addr_i < PAGE_END)) |=> wr_permit_o);

    // R7: an array attempt consumes the enable latch
    a_r7_attempt_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req_i && !busy_i) |=> !status_o[1]);

    // R2: disable event clears the latch
    a_r2_wrdi_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wrdi_i && !busy_i) |=> !wel_q);

    // R9: protection fields held while programming
    a_r9_frozen_fields: assert property (@(posedge clk) disable iff (!rst_n || !nv_init_n)
        (busy_i && $past(busy_i)) |-> ($stable(status_o[7]) && $stable(status_o[3:2])));

endmodule

bind wprot_status_ctrl wps_checker #(
    .ADDR_W    (ADDR_W),
    .PAGE_BYTES(PAGE_BYTES)
) u_wps_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .nv_init_n  (nv_init_n),
    .wp_n_i     (wp_n_i),
    .wrdi_i     (wrdi_i),
    .wrsr_req_i (wrsr_req_i),
    .arr_req_i  (arr_req_i),
    .arr_addr_i (arr_addr_i),
    .busy_i     (busy_i),
    .wr_permit_o(wr_permit_o),
    .status_o   (status_o),
    .srwd_st    (srwd_st),
    .wel_q      (wel_q)
);

// File: tb/wprot_status_ctrl_bench.sv
// Bench: behavioural reference model compared on every clock, plus spot checks
// of literal status values.
module wprot_status_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nv_init_n = 1'b0;
    logic       wp_n_i = 1'b1;
    logic       wren_i = 1'b0;
    logic       wrdi_i = 1'b0;
    logic       wrsr_req_i = 1'b0;
    logic [5:0] wrsr_clks_i = '0;
    logic [7:0] wrsr_data_i = '0;
    logic       arr_req_i = 1'b0;
    logic [9:0] arr_addr_i = '0;
    logic       busy_i = 1'b0;
    logic       cmp_upd_i = 1'b0;
    logic       cmp_lower_i = 1'b0;
    logic       erased_i = 1'b0;
    logic       wr_permit_o;
    logic [7:0] status_o;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit cmp_en = 0;
    string tag = "R1";

    // reference model state
    bit m_wel, m_lock, m_lock_s, m_inc, m_permit;
    int m_fence, m_fence_s;

    always #4 clk = ~clk;

    wprot_status_ctrl u_wprot_status_ctrl (
        .clk(clk), .rst_n(rst_n), .nv_init_n(nv_init_n), .wp_n_i(wp_n_i),
        .wren_i(wren_i), .wrdi_i(wrdi_i), .wrsr_req_i(wrsr_req_i),
        .wrsr_clks_i(wrsr_clks_i), .wrsr_data_i(wrsr_data_i),
        .arr_req_i(arr_req_i), .arr_addr_i(arr_addr_i), .busy_i(busy_i),
        .cmp_upd_i(cmp_upd_i), .cmp_lower_i(cmp_lower_i), .erased_i(erased_i),
        .wr_permit_o(wr_permit_o), .status_o(status_o)
    );

    function automatic bit fenced(int a, int code);
        if (a < 32) return 0;
        case (code)
            1: return a >= 768;
            2: return a >= 512;
            3: return 1;
            default: return 0;
        endcase
    endfunction

    // reference model, updated from the inputs seen at each edge
    always @(posedge clk) begin
        bit old_lock, old_permit, grant;
        int old_fence;
        old_lock = m_lock; old_fence = m_fence; old_permit = m_permit;
        grant = 0;
        if (!nv_init_n) begin
            m_lock = 0; m_fence = 0; m_lock_s = 0; m_fence_s = 0; m_inc = 1;
        end else begin
            if (!busy_i && !old_permit) begin m_lock_s = old_lock; m_fence_s = old_fence; end
            if (cmp_upd_i) m_inc = cmp_lower_i;
        end
        if (!rst_n) begin
            m_wel = 0;
        end else if (!busy_i) begin
            if (arr_req_i) begin
                grant = m_wel && !fenced(int'(arr_addr_i), old_fence);
                m_wel = 0;
            end else if (wrsr_req_i && wrsr_clks_i == 16) begin
                grant = m_wel && !(old_lock && !wp_n_i);
                if (grant && nv_init_n) begin
                    m_lock = wrsr_data_i[7];
                    m_fence = int'(wrsr_data_i[3:2]);
                end
                m_wel = 0;
            end else if (wrdi_i) m_wel = 0;
            else if (wren_i) m_wel = 1;
        end
        m_permit = grant;
        cycles++;
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (cmp_en) begin
            logic [7:0] exp_s;
            exp_s = {m_lock_s, erased_i, 1'b0, m_inc, 2'(m_fence_s), m_wel, busy_i};
            compared++;
            if (status_o !== exp_s) begin
                mismatched++;
                $display("FAIL %s status act=%h exp=%h t=%0t", tag, status_o, exp_s, $time);
            end
            compared++;
            if (wr_permit_o !== m_permit) begin
                mismatched++;
                $display("FAIL %s permit act=%b exp=%b t=%0t", tag, wr_permit_o, m_permit, $time);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cycles > 20000) begin
            mismatched++;
            $display("FAIL watchdog act=%0d exp<=20000 cycles", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic spot(string t, logic [7:0] act, logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s spot act=%h exp=%h", t, act, exp);
        end
    endtask

    task automatic ev_wren(); wren_i = 1; tick(); wren_i = 0; endtask
    task automatic ev_wrdi(); wrdi_i = 1; tick(); wrdi_i = 0; endtask

    task automatic ev_wrsr(logic [7:0] d, int clks);
        wrsr_data_i = d; wrsr_clks_i = 6'(clks); wrsr_req_i = 1; tick(); wrsr_req_i = 0;
    endtask

    task automatic ev_arr(int a);
        arr_addr_i = 10'(a); arr_req_i = 1; tick(); arr_req_i = 0; tick();
    endtask

    // enabled status write, then leave time for the shown copy
    task automatic set_fields(logic [7:0] d);
        ev_wren(); ev_wrsr(d, 16); tick(3);
    endtask

    task automatic sweep(int code);
        int pts[8] = '{0, 31, 32, 511, 512, 767, 768, 1023};
        tag = "R5";
        foreach (pts[i]) begin
            ev_wren();
            ev_arr(pts[i]);
        end
    endtask

    initial begin
        tick(1);
        cmp_en = 1;
        tick(2);
        nv_init_n = 1; rst_n = 1;
        tick(1);
        tag = "R1";
        spot("R1", status_o, 8'h10);

        tag = "R6"; ev_arr(12'h300 & 10'h3FF); ev_arr(5);
        tag = "R2"; ev_wren(); spot("R2", status_o, 8'h12);
        ev_wrdi(); spot("R2", status_o, 8'h10);
        ev_wren(); wren_i = 1; wrdi_i = 1; tick(); wren_i = 0; wrdi_i = 0;
        spot("R2", status_o, 8'h10);

        tag = "R3"; ev_wren(); ev_wrsr(8'hFF, 15); ev_wrsr(8'hFF, 17); tick();
        spot("R3", status_o, 8'h12);
        ev_wrsr(8'hFF, 16);
        // permit visible now; start programming
        tag = "R9"; busy_i = 1; tick();
        spot("R9", status_o, 8'h11);
        tag = "R8"; ev_wren(); ev_wrdi(); ev_arr(40); ev_wrsr(8'h00, 16);
        tick(2); busy_i = 0; tick(1);
        tag = "R9"; spot("R9", status_o, 8'h9C);

        sweep(3);
        tag = "R4"; wp_n_i = 0; ev_wren(); ev_wrsr(8'h04, 16); tick(2);
        spot("R4", status_o, 8'h9C);
        tag = "R7"; spot("R7", status_o & 8'h02, 8'h00);
        tag = "R4"; wp_n_i = 1; set_fields(8'h04);
        spot("R4", status_o, 8'h14);
        sweep(1);
        set_fields(8'h08); sweep(2);
        tag = "R4"; wp_n_i = 0; set_fields(8'h00);
        spot("R4", status_o, 8'h10);
        wp_n_i = 1; set_fields(8'h8C);

        tag = "R2"; ev_wren(); rst_n = 0; tick(); rst_n = 1; tick();
        spot("R2", status_o, 8'h9C);

        tag = "R10"; cmp_lower_i = 0; cmp_upd_i = 1; tick(); cmp_upd_i = 0;
        erased_i = 1; tick();
        spot("R10", status_o, 8'hCC);
        cmp_lower_i = 1; cmp_upd_i = 1; tick(); cmp_upd_i = 0; erased_i = 0; tick();
        spot("R10", status_o, 8'h9C);

        tag = "R7"; ev_wren(); ev_arr(1023); spot("R7", status_o & 8'h02, 8'h00);
        tag = "R1"; nv_init_n = 0; tick(); nv_init_n = 1; tick(2);
        spot("R1", status_o, 8'h10);

        tick(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule